// File: doc/BRIEF.md
# SPI Channel FIFO, Status and Interrupt Unit

This block sits between a simple register bus and the serial shift engine of one SPI channel. It holds an eight-word transmit queue and an eight-word receive queue of 32-bit words. It also keeps a sticky event register, an interrupt mask and a threshold setting for the channel, and it drives one interrupt line. Software fills the transmit queue through a data register and drains the receive queue through another. The shift engine pulls transmit words on request and hands back received words, and it reports when a transfer starts and ends.

The channel recognises only its own slice of the shared register space. Channels repeat every 0x40 bytes, and the `CH_ID` parameter selects which slice belongs to this instance. Beside the data traffic, the unit records five kinds of event: a transmit fill that falls to its threshold, a receive fill that climbs to its threshold, an engine pull from an empty transmit queue, a received word that arrives at a full receive queue, and transfer completion. A sixth sticky bit records that a transfer is pending. Each event bit stays set until software writes a 1 to it.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the event register (offset 0x0C) reads 0, the mask (0x10) reads 0, the threshold (0x14) reads 0x80, the fill-count register (0x18) reads 0, `eng_tx_data` is 0 and `irq` is 0.
- R2: A bus write to offset 0x1C appends a word to the transmit queue while its fill is below 8, and is ignored when the fill is 8. Fill-count bits [7:4] show the transmit fill. Each `eng_tx_req` cycle pops the head, which `eng_tx_data` presents in write order.
- R3: `eng_rx_push` appends `eng_rx_data` to the receive queue. Fill-count bits [3:0] show the receive fill. A bus read of offset 0x20 returns the oldest word and pops it. A read of 0x20 on an empty queue returns 0 and changes nothing.
- R4: `eng_tx_req` on an empty transmit queue supplies 0 on `eng_tx_data` and sets event bit 4.
- R5: `eng_rx_push` while the receive fill is 8 drops the word, leaves the fill at 8 and sets event bit 5.
- R6: Event bit 2 sets when the transmit fill moves from above to at or below threshold bits [3:0]. The unit stores the threshold register from bus writes to offset 0x14.
- R7: Event bit 3 sets when the receive fill moves from below to at or above threshold bits [7:4].
- R8: An `eng_start` pulse sets event bit 0 and an `eng_done` pulse sets event bit 1.
- R9: Writing the event register clears each bit written as 1 and leaves the bits written as 0. Writing back a value just read clears exactly those bits. An event that is raised in the same cycle as its clear stays set.
- R10: `irq` is high exactly when an enabled event is set. Mask bit 0 enables event bit 1, mask bit 1 enables event bit 2, mask bit 2 enables event bit 3, mask bit 3 enables event bit 4 and mask bit 4 enables event bit 5. Event bit 0 never raises `irq`.
- R11: Accesses whose address bits [ADDR_W-1:6] differ from `CH_ID` have no effect and read 0. Offsets this unit does not hold read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at offset 0x20) |
| bus_addr | input | ADDR_W | Byte address: channel index above bit 5, offset below |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| eng_tx_req | input | 1 | Engine takes one transmit word |
| eng_tx_data | output | DATA_W | Head of the transmit queue, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers one received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_start | input | 1 | Transfer started pulse |
| eng_done | input | 1 | Transfer finished pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with four channels, `CH_ID` set to 2 and an eight-word depth. With channel 2 selected, the bench can probe foreign slices both below and above its own slice, and so checks the decode from both sides. The shallow depth lets the bench reach a full queue, a write past full, an overflow and an underflow in a few dozen cycles. The bench also walks the default threshold of 0x80 and a custom threshold of 0x42, so both threshold crossings are seen at two different levels.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int SLICE_W = 6;

  localparam logic [SLICE_W-1:0] OFF_STAT = 6'h0C;
  localparam logic [SLICE_W-1:0] OFF_MASK = 6'h10;
  localparam logic [SLICE_W-1:0] OFF_THR  = 6'h14;
  localparam logic [SLICE_W-1:0] OFF_FILL = 6'h18;
  localparam logic [SLICE_W-1:0] OFF_TXD  = 6'h1C;
  localparam logic [SLICE_W-1:0] OFF_RXD  = 6'h20;

  localparam int NUM_EVT = 6;
  localparam int NUM_EN  = NUM_EVT - 1;

  localparam int EV_PEND = 0;
  localparam int EV_DONE = 1;
  localparam int EV_TXLO = 2;
  localparam int EV_RXHI = 3;
  localparam int EV_TXUF = 4;
  localparam int EV_RXOF = 5;

  typedef struct packed {
    logic rxof;
    logic txuf;
    logic rxhi;
    logic txlo;
    logic done;
    logic pend;
  } evt_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  p_fifo_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_fifo_pop_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_fifo_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   tx_cnt,
  input  logic [CNT_W-1:0]   rx_cnt,
  input  logic [CNT_W-1:0]   tx_thr,
  input  logic [CNT_W-1:0]   rx_thr,
  input  logic               pend_set,
  input  logic               done_set,
  input  logic               txuf_set,
  input  logic               rxof_set,
  input  logic               stat_wr,
  input  logic [NUM_EVT-1:0] stat_wdata,
  input  logic               mask_wr,
  input  logic [NUM_EN-1:0]  mask_wdata,
  output logic [NUM_EVT-1:0] status,
  output logic [NUM_EN-1:0]  mask,
  output logic               irq
);
  logic tx_low, rx_high;
  logic tx_low_q, rx_high_q;
  evt_t raise;
  logic [NUM_EVT-1:0] stat_q, stat_d, clr;
  logic [NUM_EN-1:0]  mask_q, mask_d;

  assign tx_low  = (tx_cnt <= tx_thr);
  assign rx_high = (rx_cnt >= rx_thr);

  always_comb begin
    raise.pend = pend_set;
    raise.done = done_set;
    raise.txlo = tx_low && !tx_low_q;
    raise.rxhi = rx_high && !rx_high_q;
    raise.txuf = txuf_set;
    raise.rxof = rxof_set;
    clr    = stat_wr ? stat_wdata : '0;
    stat_d = (stat_q & ~clr) | raise;
    mask_d = mask_wr ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      mask_q    <= '0;
      tx_low_q  <= 1'b1;
      rx_high_q <= 1'b0;
    end else begin
      stat_q    <= stat_d;
      mask_q    <= mask_d;
      tx_low_q  <= tx_low;
      rx_high_q <= rx_high;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q[NUM_EVT-1:1] & mask_q);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> status[EV_DONE]);
  p_clear_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[EV_TXUF] && !txuf_set) |=> !status[EV_TXUF]);
  p_hold_unwritten_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && status[EV_RXOF]) |=> status[EV_RXOF]);
  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));
  p_tx_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_low && !tx_low_q) |=> status[EV_TXLO]);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_ID  = 0,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + SLICE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_tx_req,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_start,
  input  logic              eng_done,
  output logic              irq
);
  logic [SLICE_W-1:0] off;
  logic               hit;
  logic               tx_push, tx_pop, tx_full, tx_empty, tx_uf;
  logic               rx_push, rx_pop, rx_full, rx_empty, rx_of;
  logic [DATA_W-1:0]  tx_head, rx_head, rd_mux;
  logic [CNT_W-1:0]   tx_cnt, rx_cnt;
  logic [2*CNT_W-1:0] thr_q, thr_d;
  logic               thr_wr, stat_wr, mask_wr;
  logic [NUM_EVT-1:0] status;
  logic [NUM_EN-1:0]  mask;

  assign off     = bus_addr[SLICE_W-1:0];
  assign hit     = bus_sel && (bus_addr[ADDR_W-1:SLICE_W] == CH_W'(CH_ID));
  assign stat_wr = hit && bus_wr && (off == OFF_STAT);
  assign mask_wr = hit && bus_wr && (off == OFF_MASK);
  assign thr_wr  = hit && bus_wr && (off == OFF_THR);

  assign tx_push = hit && bus_wr && (off == OFF_TXD) && !tx_full;
  assign tx_pop  = eng_tx_req && !tx_empty;
  assign tx_uf   = eng_tx_req && tx_empty;
  assign rx_push = eng_rx_push && !rx_full;
  assign rx_of   = eng_rx_push && rx_full;
  assign rx_pop  = hit && bus_rd && (off == OFF_RXD) && !rx_empty;

  spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_wdata),
    .pop(tx_pop), .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(eng_rx_data),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  always_comb thr_d = thr_wr ? bus_wdata[2*CNT_W-1:0] : thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= {CNT_W'(DEPTH), CNT_W'(0)};
    else        thr_q <= thr_d;
  end

  spi_evt_ctrl #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_thr(thr_q[CNT_W-1:0]), .rx_thr(thr_q[2*CNT_W-1:CNT_W]),
    .pend_set(eng_start), .done_set(eng_done), .txuf_set(tx_uf), .rxof_set(rx_of),
    .stat_wr(stat_wr), .stat_wdata(bus_wdata[NUM_EVT-1:0]),
    .mask_wr(mask_wr), .mask_wdata(bus_wdata[NUM_EN-1:0]),
    .status(status), .mask(mask), .irq(irq));

  always_comb begin
    rd_mux = '0;
    case (off)
      OFF_STAT: rd_mux = DATA_W'(status);
      OFF_MASK: rd_mux = DATA_W'(mask);
      OFF_THR:  rd_mux = DATA_W'(thr_q);
      OFF_FILL: rd_mux = DATA_W'({tx_cnt, rx_cnt});
      OFF_RXD:  rd_mux = rx_empty ? '0 : rx_head;
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata   = hit ? rd_mux : '0;
  assign eng_tx_data = tx_empty ? '0 : tx_head;

  p_underflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_req && tx_empty) |=> status[EV_TXUF]);
  p_overflow_keep_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_full && !rx_pop) |=> (rx_full && status[EV_RXOF]));
  p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_rd && (off == OFF_RXD) && rx_empty) |-> (bus_rdata == '0));
  p_foreign_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !hit) |=> ($stable(mask) && $stable(thr_q) && $stable(tx_cnt)));
endmodule

// File: tb/sim_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_unit;
  localparam int CH   = 2;
  localparam int BASE = CH * 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_tx_req = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        eng_start = 1'b0, eng_done = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_fifo_irq_unit #(.NUM_CH(4), .CH_ID(CH), .DATA_W(32), .DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_start(eng_start), .eng_done(eng_done), .irq(irq));

  // {op, offset, data}: op 0 = write, op 1 = read and compare
  localparam logic [41:0] VEC [13] = '{
    {2'd1, 8'h0C, 32'h0000_0000},  // R1
    {2'd1, 8'h10, 32'h0000_0000},  // R1
    {2'd1, 8'h14, 32'h0000_0080},  // R1
    {2'd1, 8'h18, 32'h0000_0000},  // R1
    {2'd0, 8'h1C, 32'h1111_1111},  // R2
    {2'd0, 8'h1C, 32'h2222_2222},  // R2
    {2'd1, 8'h18, 32'h0000_0020},  // R2
    {2'd1, 8'h1C, 32'h0000_0000},  // R11
    {2'd0, 8'h10, 32'h0000_001F},  // R10
    {2'd1, 8'h10, 32'h0000_001F},  // R10
    {2'd0, 8'h10, 32'h0000_0000},  // R10
    {2'd1, 8'h00, 32'h0000_0000},  // R11
    {2'd1, 8'h0C, 32'h0000_0000}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_abs(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_abs(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    wr_abs(8'(BASE) + off, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input logic [31:0] exp);
    logic [31:0] v;
    rd_abs(8'(BASE) + off, v);
    chk(req, v, exp);
  endtask

  task automatic tx_take(output logic [31:0] d);
    @(negedge clk);
    eng_tx_req = 1'b1;
    #1 d = eng_tx_data;
    @(negedge clk);
    eng_tx_req = 1'b0;
  endtask

  task automatic rx_give(input logic [31:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx data", eng_tx_data, 32'd0);

    for (int i = 0; i < 13; i++) begin
      if (VEC[i][41:40] == 2'd0) wr(VEC[i][39:32], VEC[i][31:0]);
      else rd_chk("R1/R2/R10/R11 table", VEC[i][39:32], VEC[i][31:0]);
    end

    // R2 order, R6 crossing to zero, R9 clear
    tx_take(v); chk("R2 head 0", v, 32'h1111_1111);
    tx_take(v); chk("R2 head 1", v, 32'h2222_2222);
    idle(1);
    rd_chk("R6 tx low event", 8'h0C, 32'h04);
    wr(8'h0C, 32'h04);
    rd_chk("R9 clear", 8'h0C, 32'h00);

    // R4 underflow, R9 write-back
    tx_take(v); chk("R4 zero supplied", v, 32'd0);
    rd_chk("R4 flag", 8'h0C, 32'h10);
    rd_abs(8'(BASE) + 8'h0C, v);
    wr(8'h0C, v);
    rd_chk("R9 write-back", 8'h0C, 32'h00);

    // R2 fill past full
    for (int i = 0; i < 10; i++) wr(8'h1C, 32'hA000_0000 + 32'(i));
    rd_chk("R2 fill full", 8'h18, 32'h80);
    for (int i = 0; i < 8; i++) begin
      tx_take(v); chk("R2 drain order", v, 32'hA000_0000 + 32'(i));
    end
    idle(1);
    rd_chk("R2/R6 empty again", 8'h0C, 32'h04);
    wr(8'h0C, 32'h3F);

    // R3 receive order and empty read
    for (int i = 0; i < 3; i++) rx_give(32'hB0 + 32'(i));
    rd_chk("R3 rx fill", 8'h18, 32'h03);
    for (int i = 0; i < 3; i++) rd_chk("R3 rx order", 8'h20, 32'hB0 + 32'(i));
    rd_chk("R3 empty read", 8'h20, 32'h0);
    rd_chk("R3 fill unchanged", 8'h18, 32'h0);
    rd_chk("R7 no early event", 8'h0C, 32'h0);

    // R7 threshold at 8, R5 overflow
    for (int i = 0; i < 9; i++) rx_give(32'hC0 + 32'(i));
    idle(1);
    rd_chk("R5/R7 events", 8'h0C, 32'h28);
    rd_chk("R5 fill held", 8'h18, 32'h08);
    for (int i = 0; i < 8; i++) rd_chk("R5 dropped word", 8'h20, 32'hC0 + 32'(i));
    rd_chk("R3 empty after drain", 8'h20, 32'h0);
    wr(8'h0C, 32'h3F);
    rd_chk("R9 all clear", 8'h0C, 32'h0);

    // R10 mapping, R8
    wr(8'h10, 32'h10);
    pulse_done();
    rd_chk("R8 done", 8'h0C, 32'h02);
    chk("R10 masked", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h01);
    chk("R10 done enabled", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h02);
    chk("R10 after clear", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h1F);
    @(negedge clk); eng_start = 1'b1;
    @(negedge clk); eng_start = 1'b0;
    rd_chk("R8 pending", 8'h0C, 32'h01);
    chk("R10 pending no irq", {31'd0, irq}, 32'd0);
    wr(8'h0C, 32'h01);

    // R9 raise beats clear
    @(negedge clk);
    eng_done = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1;
    bus_addr = 8'(BASE) + 8'h0C; bus_wdata = 32'h02;
    @(negedge clk);
    eng_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd_chk("R9 set wins", 8'h0C, 32'h02);
    chk("R10 irq on", {31'd0, irq}, 32'd1);

    // R11 decode
    wr_abs(8'h10, 32'h0);
    rd_chk("R11 mask kept", 8'h10, 32'h1F);
    rd_abs(8'hCC, v); chk("R11 foreign read", v, 32'h0);
    wr_abs(8'h1C, 32'hDEAD_BEEF);
    wr_abs(8'hDC, 32'hDEAD_BEEF);
    rd_chk("R11 no foreign push", 8'h18, 32'h0);
    wr(8'h0C, 32'h3F);

    // R6/R7 with threshold 0x42
    wr(8'h14, 32'h42);
    rd_chk("R6 thr stored", 8'h14, 32'h42);
    for (int i = 0; i < 4; i++) rx_give(32'hE0 + 32'(i));
    idle(1);
    rd_chk("R7 rx at 4", 8'h0C, 32'h08);
    for (int i = 0; i < 3; i++) wr(8'h1C, 32'hF0 + 32'(i));
    tx_take(v); chk("R2 head", v, 32'hF0);
    idle(1);
    rd_chk("R6 tx at 2", 8'h0C, 32'h0C);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule